// File: doc/BRIEF.md
# GPIO Interrupt Cause and Mask Unit

This block is the interrupt front end of one 32-pin GPIO bank. Every pin is first brought into the core clock domain by a two-flop synchronizer. It is then XORed with a programmable polarity bit, so software decides per pin which level counts as active. The polarity-adjusted value feeds two request paths. The level path uses the value directly, with no storage, so a level request follows the pin. The edge path detects a rising transition of the adjusted value and latches it into an edge cause register. Software clears that register by writing zero to a bit.

Each path has its own mask register. A direction register marks which pins are inputs, and only those pins can raise a request. The masked requests of each group of eight neighbouring pins are ORed into one summary interrupt line, so a 32-pin bank drives four lines. Software reaches all registers through a small single-cycle register bus, and read data returns one cycle after the request.

Top module: `gpio_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and all summary lines are low.
- R2: The data-in register (address 5) reads the synchronized pin value XOR the polarity register (address 1). A pin change becomes visible two clock edges after it is applied.
- R3: A level request for a pin is (adjusted value AND level mask bit, address 3). It is not latched and drops as soon as the adjusted value returns to 0.
- R4: A 0-to-1 transition of a pin's adjusted value sets that pin's bit in the edge cause register (address 4). The bit stays set after the pin returns, and a 1-to-0 transition sets nothing.
- R5: An edge cause bit raises its summary line only while its edge mask bit (address 2) is 1.
- R6: Writing the edge cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: When a rising edge arrives on the same clock edge as a write that clears its bit, the bit ends up set.
- R8: Summary line k (irq_o[k]) is the OR of the masked edge and masked level requests of pins 8k to 8k+7.
- R9: A pin whose bit in the direction register (address 0, 1 = input) is 0 raises no level request and sets no edge cause bit.
- R10: Addresses 0 to 3 read back the last value written. Read data is valid in the cycle after the request and is 0 otherwise. Addresses 6 and 7 read 0, and writes to address 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_o | output | 4 | Summary interrupt per group of eight pins |

## Verification
The bench targets a clear write that lands on the same edge as a new rising edge. A design that lets the clear win loses that event without a trace. It checks that a cause bit survives the pin falling back, and that a falling edge latches nothing. A latch on the wrong transition, or a cause that tracks the pin, would fail those checks. Pins configured as outputs are toggled to show they request nothing, which catches a direction gate that is missing or inverted. A table of polarity, mask and pin patterns spread across all four groups catches summary lines that OR the wrong eight pins.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the GPIO interrupt unit: bus address width and register map.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR    = 3'd0,
        REG_POL    = 3'd1,
        REG_EMASK  = 3'd2,
        REG_LMASK  = 3'd3,
        REG_CAUSE  = 3'd4,
        REG_DATAIN = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes every bit is independent; no bus coherency is implied.
module gpio_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin values one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage[s] <= '0;
                end else if (s == 0) begin
                    stage[s] <= d;
                end else begin
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
// Register file and bus decode for the GPIO interrupt unit.
// Holds direction, polarity and both masks, forms the write-zero-to-clear
// mask for the edge cause register, and returns registered read data.
// Assumes single-cycle requests: bus_en is sampled on each rising edge.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] datain,
    input  logic [DATA_W-1:0] cause,
    output logic [DATA_W-1:0] dir,
    output logic [DATA_W-1:0] pol,
    output logic [DATA_W-1:0] emask,
    output logic [DATA_W-1:0] lmask,
    output logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              wr_req;
    logic              rd_req;
    logic [DATA_W-1:0] rd_mux;

    assign wr_req = bus_en &  bus_we;
    assign rd_req = bus_en & ~bus_we;

    // Capture software writes to the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir   <= '0;
            pol   <= '0;
            emask <= '0;
            lmask <= '0;
        end else if (wr_req) begin
            case (bus_addr)
                REG_DIR:   dir   <= bus_wdata;
                REG_POL:   pol   <= bus_wdata;
                REG_EMASK: emask <= bus_wdata;
                REG_LMASK: lmask <= bus_wdata;
                default:   ;
            endcase
        end
    end

    // Bits written as zero to the cause register are to be cleared.
    always_comb begin
        clr_mask = '0;
        if (wr_req && (bus_addr == REG_CAUSE)) begin
            clr_mask = ~bus_wdata;
        end
    end

    // Select the register addressed by a read.
    always_comb begin
        case (bus_addr)
            REG_DIR:    rd_mux = dir;
            REG_POL:    rd_mux = pol;
            REG_EMASK:  rd_mux = emask;
            REG_LMASK:  rd_mux = lmask;
            REG_CAUSE:  rd_mux = cause;
            REG_DATAIN: rd_mux = datain;
            default:    rd_mux = '0;
        endcase
    end

    // Register read data; it is zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_req ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/gpio_irq_cause.sv
`timescale 1ns/1ps
// Polarity adjustment, rising-edge detection and edge cause latch.
// Assumes sync_in is already in the clk domain. A new edge beats a
// same-cycle clear. Only pins marked as inputs can set a cause bit.
module gpio_irq_cause #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] adj,
    output logic [WIDTH-1:0] adj_q,
    output logic [WIDTH-1:0] cause
);
    logic [WIDTH-1:0] rising;

    // Apply the per-pin polarity and find qualified rising transitions.
    always_comb begin
        adj    = sync_in ^ pol;
        rising = adj & ~adj_q & dir;
    end

    // Keep last cycle's adjusted value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q <= '0;
        end else begin
            adj_q <= adj;
        end
    end

    // Latch edges and apply software clears, with the set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause <= '0;
        end else begin
            cause <= (cause & ~clr_mask) | rising;
        end
    end
endmodule

// File: rtl/gpio_irq_summary.sv
`timescale 1ns/1ps
// Combines masked edge and level requests and ORs them per group of pins.
// Assumes WIDTH is a whole multiple of GROUP_W.
module gpio_irq_summary #(
    parameter int WIDTH   = 32,
    parameter int GROUP_W = 8,
    localparam int NGROUPS = WIDTH / GROUP_W
) (
    input  logic [WIDTH-1:0]   cause,
    input  logic [WIDTH-1:0]   emask,
    input  logic [WIDTH-1:0]   adj,
    input  logic [WIDTH-1:0]   lmask,
    input  logic [WIDTH-1:0]   dir,
    output logic [NGROUPS-1:0] irq
);
    logic [WIDTH-1:0] req;

    // Per-pin request from either path.
    always_comb begin
        req = (cause & emask) | (adj & lmask & dir);
    end

    genvar g;
    generate
        for (g = 0; g < NGROUPS; g++) begin : g_grp
            // One summary line per group of neighbouring pins.
            assign irq[g] = |req[g*GROUP_W +: GROUP_W];
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_unit.sv
`timescale 1ns/1ps
// GPIO bank interrupt front end: synchronizer, polarity, level and edge
// request paths with masks, and grouped summary interrupt lines.
// Assumes pins are asynchronous to clk and the bus is in the clk domain.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int GROUP_W     = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NGROUPS    = NPINS / GROUP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NPINS-1:0]   pin_i,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]   bus_rdata,
    output logic [NGROUPS-1:0] irq_o
);
    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] dir;
    logic [NPINS-1:0] pol;
    logic [NPINS-1:0] emask;
    logic [NPINS-1:0] lmask;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] adj;
    logic [NPINS-1:0] adj_q;
    logic [NPINS-1:0] cause;

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_i),
        .q     (sync_in)
    );

    gpio_irq_regs #(.DATA_W(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .datain    (adj),
        .cause     (cause),
        .dir       (dir),
        .pol       (pol),
        .emask     (emask),
        .lmask     (lmask),
        .clr_mask  (clr_mask),
        .bus_rdata (bus_rdata)
    );

    gpio_irq_cause #(.WIDTH(NPINS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .pol      (pol),
        .dir      (dir),
        .clr_mask (clr_mask),
        .adj      (adj),
        .adj_q    (adj_q),
        .cause    (cause)
    );

    gpio_irq_summary #(.WIDTH(NPINS), .GROUP_W(GROUP_W)) u_sum (
        .cause (cause),
        .emask (emask),
        .adj   (adj),
        .lmask (lmask),
        .dir   (dir),
        .irq   (irq_o)
    );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
`timescale 1ns/1ps
// Property checker for gpio_irq_unit, attached with bind below.
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS   = 32,
    parameter int GROUP_W = 8,
    localparam int NGROUPS = NPINS / GROUP_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NPINS-1:0]   bus_wdata,
    input logic [NPINS-1:0]   bus_rdata,
    input logic [NGROUPS-1:0] irq_o,
    input logic [NPINS-1:0]   adj,
    input logic [NPINS-1:0]   dir,
    input logic [NPINS-1:0]   emask,
    input logic [NPINS-1:0]   lmask,
    input logic [NPINS-1:0]   cause
);
    // R4
    cause_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~$past(cause) & ~$past(adj)) == '0));

    // R9
    output_pin_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~$past(cause) & ~$past(dir)) == '0));

    // R6
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == REG_CAUSE)
        |=> ((cause & ~$past(bus_wdata) & ~$past(adj)) == '0));

    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emask == '0 && lmask == '0) |-> (irq_o == '0));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr > REG_DATAIN) |=> (bus_rdata == '0));

    genvar g;
    generate
        for (g = 0; g < NGROUPS; g++) begin : g_lvl
            // R3
            level_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((adj[g*GROUP_W +: GROUP_W] & lmask[g*GROUP_W +: GROUP_W]
                  & dir[g*GROUP_W +: GROUP_W]) != '0) |-> irq_o[g]);
        end
    endgenerate
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.NPINS(NPINS), .GROUP_W(GROUP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .adj       (adj),
    .dir       (dir),
    .emask     (emask),
    .lmask     (lmask),
    .cause     (cause)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
// Self-checking bench for gpio_irq_unit.
module gpio_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_i = '0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [2:0] A_DIR = 3'd0, A_POL = 3'd1, A_EMASK = 3'd2,
                           A_LMASK = 3'd3, A_CAUSE = 3'd4, A_DATAIN = 3'd5;

    typedef struct packed {
        logic [31:0] pol;
        logic [31:0] lmask;
        logic [31:0] pins;
        logic [31:0] exp_din;
        logic [3:0]  exp_irq;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001, 4'b0001},
        '{32'h0000_0000, 32'h0000_FF00, 32'h0000_0001, 32'h0000_0001, 4'b0000},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 4'b0000},
        '{32'hFF00_0000, 32'hFF00_0000, 32'h0000_0000, 32'hFF00_0000, 4'b1000},
        '{32'h0000_0000, 32'h00FF_00FF, 32'h8080_8080, 32'h8080_8080, 4'b0101},
        '{32'h0F0F_0F0F, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000, 4'b0000},
        '{32'h0000_0000, 32'h00FF_FF00, 32'h0001_0000, 32'h0001_0000, 4'b0100}
    };

    gpio_irq_unit u_gpio_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    // Apply pins, then wait until a resulting edge cause is visible.
    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_i = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {28'd0, irq_o}, 32'd0);
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), rd);
            check("R1 reg", rd, 32'd0);
        end

        // R10 readback, unmapped and read-only addresses
        bus_write(A_DIR, 32'hFFFF_FFFF);   bus_read(A_DIR, rd);   check("R10 dir", rd, 32'hFFFF_FFFF);
        bus_write(A_POL, 32'h5A5A_5A5A);   bus_read(A_POL, rd);   check("R10 pol", rd, 32'h5A5A_5A5A);
        bus_write(A_EMASK, 32'h0F0F_0F0F); bus_read(A_EMASK, rd); check("R10 emask", rd, 32'h0F0F_0F0F);
        bus_write(A_EMASK, 32'h0);
        bus_write(A_LMASK, 32'h1234_5678); bus_read(A_LMASK, rd); check("R10 lmask", rd, 32'h1234_5678);
        bus_write(A_LMASK, 32'h0);
        bus_read(3'd6, rd); check("R10 addr6", rd, 32'd0);
        bus_read(3'd7, rd); check("R10 addr7", rd, 32'd0);
        bus_write(A_DATAIN, 32'hFFFF_FFFF);
        bus_read(A_DATAIN, rd); check("R10 datain write ignored (R2 pol only)", rd, 32'h5A5A_5A5A);
        @(negedge clk);
        check("R10 rdata idle zero", bus_rdata, 32'd0);
        bus_write(A_POL, 32'h0);

        // R2 R3 R8 table of polarity, level mask and pin patterns
        for (int i = 0; i < NVEC; i++) begin
            bus_write(A_POL, VECS[i].pol);
            bus_write(A_LMASK, VECS[i].lmask);
            set_pins(VECS[i].pins);
            check($sformatf("R8 R3 vec%0d irq", i), {28'd0, irq_o}, {28'd0, VECS[i].exp_irq});
            bus_read(A_DATAIN, rd);
            check($sformatf("R2 vec%0d datain", i), rd, VECS[i].exp_din);
        end

        // R3 level drops when pin returns
        set_pins(32'h0);
        check("R3 level not latched", {28'd0, irq_o}, 32'd0);

        // Prepare edge tests
        bus_write(A_POL, 32'h0);
        bus_write(A_LMASK, 32'h0);
        bus_write(A_CAUSE, 32'h0);
        bus_write(A_EMASK, 32'hFFFF_FFFF);
        check("R6 cleared all", {28'd0, irq_o}, 32'd0);

        // R4 rising edge latches, stays after fall
        set_pins(32'h0000_0100);
        bus_read(A_CAUSE, rd); check("R4 edge latched", rd, 32'h0000_0100);
        check("R8 group1 edge", {28'd0, irq_o}, 32'h2);
        set_pins(32'h0);
        bus_read(A_CAUSE, rd); check("R4 held, fall sets nothing", rd, 32'h0000_0100);

        // R6 write-one keeps, write-zero clears
        bus_write(A_CAUSE, 32'hFFFF_FFFF);
        bus_read(A_CAUSE, rd); check("R6 write one keeps", rd, 32'h0000_0100);
        bus_write(A_CAUSE, 32'hFFFF_FEFF);
        bus_read(A_CAUSE, rd); check("R6 write zero clears", rd, 32'h0);
        check("R6 irq low", {28'd0, irq_o}, 32'd0);

        // R5 edge mask gates summary
        bus_write(A_EMASK, 32'h0);
        set_pins(32'h8000_0000);
        bus_read(A_CAUSE, rd); check("R5 cause set unmasked", rd, 32'h8000_0000);
        check("R5 masked irq low", {28'd0, irq_o}, 32'd0);
        bus_write(A_EMASK, 32'h8000_0000);
        check("R5 mask opens irq", {28'd0, irq_o}, 32'h8);
        set_pins(32'h0);
        bus_write(A_CAUSE, 32'h0);
        bus_write(A_EMASK, 32'hFFFF_FFFF);

        // R7 set wins over same-cycle clear
        @(negedge clk);
        pin_i = 32'h0000_0008;
        @(negedge clk);
        bus_write(A_CAUSE, 32'hFFFF_FFF7);
        bus_read(A_CAUSE, rd); check("R7 set beats clear", rd, 32'h0000_0008);
        set_pins(32'h0);
        bus_write(A_CAUSE, 32'h0);

        // R9 output pins are ignored
        bus_write(A_DIR, 32'hFFFF_FF00);
        bus_write(A_LMASK, 32'hFFFF_FFFF);
        set_pins(32'h0000_0004);
        check("R9 output pin no irq", {28'd0, irq_o}, 32'd0);
        bus_read(A_CAUSE, rd); check("R9 output pin no cause", rd, 32'h0);
        set_pins(32'h0400_0004);
        check("R9 input pin irq", {28'd0, irq_o}, 32'h8);
        bus_read(A_CAUSE, rd); check("R9 input pin cause", rd, 32'h0400_0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule